// File: doc/BRIEF.md
# Branch Trace Record Writer

This block turns branch events into fixed-size trace records and writes them, one 32-bit word at a time, into a circular buffer in memory. Four address registers describe the buffer: the start address, the current write index, the exclusive end address and an interrupt threshold. A mode bit selects whether each record field is 4 bytes or 8 bytes wide. A record has three fields: branch source, branch destination and a flags field that is always written as zero. Software can also inject marker records for task switches. These markers carry a timestamp and a task id, and they use the same three-field layout as a branch record.

Capture is gated by two enable bits and by two privilege filters. When the write index moves from below the threshold to at or above it, the block raises an interrupt pulse and latches a sticky status bit. Software clears the status bit by writing 1 to it. At the end of the buffer the index returns to the start address. Configuration uses a simple register write port. Memory writes use a valid/ready handshake, one word per transfer.

Top module: `btr_writer`

## Requirements
- R1: A record is written as fields in the order source, destination, flags, with flags always zero. Word k goes to address start+4k. In 8-byte mode each field is written as its low word and then its high word.
- R2: Control bit 4 selects 8-byte fields, which gives 6 words and a 24-byte record. When it is clear, fields are 4 bytes and only the low 32 bits of each value are written, which gives 3 words and a 12-byte record. The mode is fixed at the moment a record is accepted.
- R3: A marker record has a first field of all ones except its two low bits, which hold 2'b10 for task arrival or 2'b11 for task departure. The second field holds the clock value and the third holds the task id. Markers are written whatever the enable and filter bits hold.
- R4: A branch is stored only when control bits 0 and 1 are both 1. Otherwise the branch is still handshaken, but nothing is written to memory and the index does not change.
- R5: When control bit 2 is set, branches flagged as kernel mode are dropped. When control bit 3 is set, branches not flagged as kernel mode are dropped. A dropped branch is handshaken but writes nothing and leaves the index unchanged.
- R6: After the last word of a record, the index advances by the record size. If the advanced value is at or beyond the end address, the index is set to the start address instead. The low three bits of a written start address are forced to zero.
- R7: `irq_o` pulses for one cycle after a record whose start index was below the threshold and whose advanced index, taken before the wrap, is at or above it. A threshold beyond the end address never fires. The pulse also sets `irq_sticky_o`. A write of bit 0 = 1 to register select 5 clears the sticky bit, but a pulse in the same cycle takes precedence.
- R8: Records that start at or past the threshold are written without stalling, all the way to the end of the buffer, and raise no further pulse.
- R9: New records are accepted only while no record is in flight. When a marker and a branch are offered together, the marker is taken first and `br_ready` stays low for that cycle.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R11: Reset clears all address registers, the control register and the sticky bit, and leaves no memory write pending.
- R12: A branch whose source and destination are both zero is not dropped. It is stored as a record of all-zero words.

Register select codes: 0 start address, 1 index, 2 end address, 3 threshold, 4 control, 5 status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | ADDR_W | Register write data |
| br_valid | input | 1 | Branch event offered |
| br_ready | output | 1 | Branch event taken |
| br_src | input | 64 | Branch source address |
| br_dst | input | 64 | Branch destination address |
| br_kernel | input | 1 | Branch executed in kernel mode |
| esc_valid | input | 1 | Marker record offered |
| esc_ready | output | 1 | Marker record taken |
| esc_depart | input | 1 | 1 = task departs, 0 = task arrives |
| esc_clock | input | 64 | Timestamp for the marker |
| esc_task | input | 64 | Task id for the marker |
| mem_valid | output | 1 | Memory word write pending |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_data | output | 32 | Word to write |
| idx_o | output | ADDR_W | Current write index |
| irq_o | output | 1 | Threshold interrupt pulse |
| irq_sticky_o | output | 1 | Latched interrupt status |

## Verification
The end-of-buffer wrap and the threshold interrupt can fall on the same record completion. This is provoked by setting the threshold equal to the end address, so that the pulse must fire even though the index reads back as the start address. A register write can also land in the same cycle as a record completion. In that case the record's index update must win, and a status clear in the same cycle must lose to a new pulse. A behavioural model in the bench takes every outcome of a cycle from the values held before the clock edge and compares the memory port, the index and both interrupt outputs on every clock. Memory back-pressure is switched on and off throughout the run.

// File: rtl/btr_pkg.sv
package btr_pkg;

    localparam int FIELD_W    = 64;
    localparam int WORD_W     = 32;
    localparam int NUM_FIELDS = 3;
    localparam int HALVES     = FIELD_W / WORD_W;
    localparam int MAX_WORDS  = NUM_FIELDS * HALVES;
    localparam int WORD_IDX_W = $clog2(MAX_WORDS);
    localparam int QUAL_W     = 2;

    localparam int CTL_W         = 5;
    localparam int CTL_TRACE_ON  = 0;
    localparam int CTL_STORE_ON  = 1;
    localparam int CTL_SKIP_KERN = 2;
    localparam int CTL_SKIP_USER = 3;
    localparam int CTL_WIDE      = 4;

    localparam int NARROW_BYTES = NUM_FIELDS * (WORD_W / 8);
    localparam int WIDE_BYTES   = NUM_FIELDS * (FIELD_W / 8);
    localparam int ALIGN_BITS   = 3;

    localparam logic [QUAL_W-1:0] QUAL_ARRIVE = 2'b10;
    localparam logic [QUAL_W-1:0] QUAL_DEPART = 2'b11;

    typedef enum logic [2:0] {
        SEL_BASE   = 3'd0,
        SEL_INDEX  = 3'd1,
        SEL_END    = 3'd2,
        SEL_THRESH = 3'd3,
        SEL_CTRL   = 3'd4,
        SEL_STATUS = 3'd5
    } sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } phase_e;

    function automatic logic [FIELD_W-1:0] marker_head(input logic depart);
        return {{(FIELD_W-QUAL_W){1'b1}}, (depart ? QUAL_DEPART : QUAL_ARRIVE)};
    endfunction

endpackage

// File: rtl/btr_word_sel.sv
module btr_word_sel
    import btr_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields,
    input  logic                               wide,
    input  logic [WORD_IDX_W-1:0]              word,
    output logic [WORD_W-1:0]                  data
);

    localparam int SLOTS = 1 << WORD_IDX_W;

    logic [SLOTS-1:0][WORD_W-1:0] wide_words;
    logic [SLOTS-1:0][WORD_W-1:0] narrow_words;

    generate
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
            for (genvar h = 0; h < HALVES; h++) begin : g_half
                assign wide_words[f*HALVES + h] = fields[f][h*WORD_W +: WORD_W];
            end
            assign narrow_words[f] = fields[f][WORD_W-1:0];
        end
        for (genvar s = MAX_WORDS; s < SLOTS; s++) begin : g_pad_wide
            assign wide_words[s] = '0;
        end
        for (genvar s = NUM_FIELDS; s < SLOTS; s++) begin : g_pad_narrow
            assign narrow_words[s] = '0;
        end
    endgenerate

    assign data = wide ? wide_words[word] : narrow_words[word];

endmodule

// File: rtl/btr_ptr_step.sv
module btr_ptr_step
    import btr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] endp,
    input  logic [ADDR_W-1:0] thr,
    input  logic              wide,
    output logic [ADDR_W-1:0] next_idx,
    output logic              crossed
);

    localparam logic [ADDR_W-1:0] REC_NARROW = ADDR_W'(NARROW_BYTES);
    localparam logic [ADDR_W-1:0] REC_WIDE   = ADDR_W'(WIDE_BYTES);

    logic [ADDR_W-1:0] advanced;

    always_comb begin
        advanced = start + (wide ? REC_WIDE : REC_NARROW);
        crossed  = (start < thr) && (advanced >= thr);
        next_idx = (advanced >= endp) ? base : advanced;
    end

endmodule

// File: rtl/btr_capture_gate.sv
module btr_capture_gate
    import btr_pkg::*;
(
    input  logic [CTL_W-1:0] ctrl,
    input  logic             kernel,
    output logic             keep
);

    logic enabled;
    logic filtered;

    always_comb begin
        enabled  = ctrl[CTL_TRACE_ON] && ctrl[CTL_STORE_ON];
        filtered = kernel ? ctrl[CTL_SKIP_KERN] : ctrl[CTL_SKIP_USER];
        keep     = enabled && !filtered;
    end

endmodule

// File: rtl/btr_writer.sv
module btr_writer
    import btr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              br_valid,
    output logic              br_ready,
    input  logic [63:0]       br_src,
    input  logic [63:0]       br_dst,
    input  logic              br_kernel,
    input  logic              esc_valid,
    output logic              esc_ready,
    input  logic              esc_depart,
    input  logic [63:0]       esc_clock,
    input  logic [63:0]       esc_task,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic [ADDR_W-1:0] idx_o,
    output logic              irq_o,
    output logic              irq_sticky_o
);

    localparam int BYTE_SHIFT = $clog2(WORD_W / 8);
    localparam logic [WORD_IDX_W-1:0] LAST_WIDE   = WORD_IDX_W'(MAX_WORDS - 1);
    localparam logic [WORD_IDX_W-1:0] LAST_NARROW = WORD_IDX_W'(NUM_FIELDS - 1);

    typedef struct packed {
        phase_e                           phase;
        logic [WORD_IDX_W-1:0]            word;
        logic                             wide;
        logic [ADDR_W-1:0]                start;
        logic [ADDR_W-1:0]                base;
        logic [ADDR_W-1:0]                idx;
        logic [ADDR_W-1:0]                endp;
        logic [ADDR_W-1:0]                thr;
        logic [CTL_W-1:0]                 ctrl;
        logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields;
        logic                             irq;
        logic                             sticky;
    } wr_state_t;

    wr_state_t q, d;

    logic              keep_br;
    logic [ADDR_W-1:0] step_next;
    logic              step_cross;
    logic              last_word;
    logic              rec_done;
    logic              clr_status;
    logic [WORD_W-1:0] word_data;

    btr_capture_gate u_gate (
        .ctrl   (q.ctrl),
        .kernel (br_kernel),
        .keep   (keep_br)
    );

    btr_ptr_step #(.ADDR_W(ADDR_W)) u_step (
        .start    (q.start),
        .base     (q.base),
        .endp     (q.endp),
        .thr      (q.thr),
        .wide     (q.wide),
        .next_idx (step_next),
        .crossed  (step_cross)
    );

    btr_word_sel u_word (
        .fields (q.fields),
        .wide   (q.wide),
        .word   (q.word),
        .data   (word_data)
    );

    always_comb begin
        d          = q;
        d.irq      = 1'b0;
        rec_done   = 1'b0;
        clr_status = 1'b0;
        last_word  = (q.word == (q.wide ? LAST_WIDE : LAST_NARROW));
        esc_ready  = (q.phase == ST_IDLE);
        br_ready   = (q.phase == ST_IDLE) && !esc_valid;

        case (q.phase)
            ST_IDLE: begin
                if (esc_valid) begin
                    d.phase     = ST_WRITE;
                    d.word      = '0;
                    d.wide      = q.ctrl[CTL_WIDE];
                    d.start     = q.idx;
                    d.fields[0] = marker_head(esc_depart);
                    d.fields[1] = esc_clock;
                    d.fields[2] = esc_task;
                end else if (br_valid && keep_br) begin
                    d.phase     = ST_WRITE;
                    d.word      = '0;
                    d.wide      = q.ctrl[CTL_WIDE];
                    d.start     = q.idx;
                    d.fields[0] = br_src;
                    d.fields[1] = br_dst;
                    d.fields[2] = '0;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    if (last_word) begin
                        rec_done = 1'b1;
                        d.phase  = ST_IDLE;
                        d.word   = '0;
                    end else begin
                        d.word = q.word + 1'b1;
                    end
                end
            end
            default: d.phase = ST_IDLE;
        endcase

        if (cfg_we) begin
            case (cfg_sel)
                SEL_BASE:   d.base = {cfg_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                SEL_INDEX:  d.idx  = cfg_wdata;
                SEL_END:    d.endp = cfg_wdata;
                SEL_THRESH: d.thr  = cfg_wdata;
                SEL_CTRL:   d.ctrl = cfg_wdata[CTL_W-1:0];
                SEL_STATUS: clr_status = cfg_wdata[0];
                default:    ;
            endcase
        end

        if (rec_done) begin
            d.idx = step_next;
            d.irq = step_cross;
        end
        d.sticky = (q.sticky && !clr_status) || d.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_valid    = (q.phase == ST_WRITE);
    assign mem_addr     = q.start + (ADDR_W'(q.word) << BYTE_SHIFT);
    assign mem_data     = word_data;
    assign idx_o        = q.idx;
    assign irq_o        = q.irq;
    assign irq_sticky_o = q.sticky;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R10
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R7
    AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_sticky_o); // R7
    AST_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !(mem_valid && mem_ready)) |=> $stable(idx_o)); // R4
    AST_MARKER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_valid && br_valid && esc_ready) |-> !br_ready); // R9
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (!esc_ready && !br_ready)); // R9

endmodule

// File: tb/btr_writer_tb.sv
module btr_writer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              br_valid = 1'b0;
    logic              br_ready;
    logic [63:0]       br_src = '0;
    logic [63:0]       br_dst = '0;
    logic              br_kernel = 1'b0;
    logic              esc_valid = 1'b0;
    logic              esc_ready;
    logic              esc_depart = 1'b0;
    logic [63:0]       esc_clock = '0;
    logic [63:0]       esc_task = '0;
    logic              mem_valid;
    logic              mem_ready = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_data;
    logic [ADDR_W-1:0] idx_o;
    logic              irq_o;
    logic              irq_sticky_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;

    btr_writer #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .br_valid(br_valid), .br_ready(br_ready), .br_src(br_src), .br_dst(br_dst),
        .br_kernel(br_kernel),
        .esc_valid(esc_valid), .esc_ready(esc_ready), .esc_depart(esc_depart),
        .esc_clock(esc_clock), .esc_task(esc_task),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .idx_o(idx_o), .irq_o(irq_o), .irq_sticky_o(irq_sticky_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_q[$];
    bit          m_busy, m_wide, m_irq, m_sticky;
    int          m_word;
    logic [31:0] m_start, m_base, m_idx, m_end, m_thr;
    logic [4:0]  m_ctl;
    bit          t_done, t_cross, t_clr;
    logic [31:0] t_next, t_adv;

    task automatic push_rec(input logic [63:0] f0, input logic [63:0] f1,
                            input logic [63:0] f2, input bit wide);
        logic [63:0] fl[3];
        fl[0] = f0; fl[1] = f1; fl[2] = f2;
        for (int k = 0; k < 3; k++) begin
            m_q.push_back(fl[k][31:0]);
            if (wide) m_q.push_back(fl[k][63:32]);
        end
        m_busy  = 1'b1;
        m_wide  = wide;
        m_word  = 0;
        m_start = m_idx;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.delete();
            m_busy = 0; m_wide = 0; m_irq = 0; m_sticky = 0; m_word = 0;
            m_start = 0; m_base = 0; m_idx = 0; m_end = 0; m_thr = 0; m_ctl = 0;
        end else begin
            t_done = 0; t_cross = 0; t_clr = 0; t_next = m_idx;
            m_irq = 0;
            if (!m_busy) begin
                if (esc_valid)
                    push_rec({{62{1'b1}}, (esc_depart ? 2'b11 : 2'b10)}, esc_clock, esc_task, m_ctl[4]);
                else if (br_valid && m_ctl[0] && m_ctl[1] && !(br_kernel ? m_ctl[2] : m_ctl[3]))
                    push_rec(br_src, br_dst, 64'd0, m_ctl[4]);
            end else if (mem_ready) begin
                void'(m_q.pop_front());
                m_word++;
                if (m_q.size() == 0) begin
                    t_done  = 1;
                    t_adv   = m_start + (m_wide ? 32'd24 : 32'd12);
                    t_cross = (m_start < m_thr) && (t_adv >= m_thr);
                    t_next  = (t_adv >= m_end) ? m_base : t_adv;
                    m_busy  = 0;
                end
            end
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: m_base = cfg_wdata & ~32'd7;
                    3'd1: m_idx  = cfg_wdata;
                    3'd2: m_end  = cfg_wdata;
                    3'd3: m_thr  = cfg_wdata;
                    3'd4: m_ctl  = cfg_wdata[4:0];
                    3'd5: t_clr  = cfg_wdata[0];
                    default: ;
                endcase
            end
            if (t_done) begin
                m_idx = t_next;
                m_irq = t_cross;
            end
            m_sticky = (m_sticky && !t_clr) || t_cross;
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            chk(mem_valid, m_busy, "R10 R9 mem_valid");
            if (m_busy) begin
                chk(mem_addr, m_start + 32'(4*m_word), "R1 R6 mem_addr");
                chk(mem_data, m_q[0], "R1 R2 R3 R12 mem_data");
            end
            chk(idx_o, m_idx, "R6 idx");
            chk(irq_o, m_irq, "R7 irq pulse");
            chk(irq_sticky_o, m_sticky, "R7 sticky");
            chk(esc_ready, !m_busy, "R9 esc_ready");
            chk(br_ready, !m_busy && !esc_valid, "R9 br_ready");
        end
    end

    always @(negedge clk) begin
        cycles++;
        mem_ready = stall_mode ? ((cycles % 3) != 0) : 1'b1;
    end

    // ---------------- stimulus tasks ----------------
    task automatic cfg(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send_br(input logic [63:0] s, input logic [63:0] dd, input bit kern);
        @(negedge clk);
        br_valid = 1; br_src = s; br_dst = dd; br_kernel = kern;
        #1;
        while (!br_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        br_valid = 0;
    endtask

    task automatic send_esc(input bit dep, input logic [63:0] ck, input logic [63:0] tid);
        @(negedge clk);
        esc_valid = 1; esc_depart = dep; esc_clock = ck; esc_task = tid;
        #1;
        while (!esc_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        esc_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_buf(input logic [31:0] b, input logic [31:0] i,
                           input logic [31:0] e, input logic [31:0] t);
        cfg(3'd0, b); cfg(3'd1, i); cfg(3'd2, e); cfg(3'd3, t);
    endtask

    initial begin
        while (cycles < WATCHDOG && !finished) @(negedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(idx_o, 0, "R11 idx after reset");
        chk(mem_valid, 0, "R11 no write after reset");
        chk(irq_sticky_o, 0, "R11 sticky after reset");

        // narrow buffer of four records, threshold after two
        set_buf(32'h1000, 32'h1000, 32'h1030, 32'h1018);
        cfg(3'd4, 32'b00011);
        stall_mode = 1;
        for (int n = 0; n < 4; n++) send_br(64'hAAAA_0000_1111_0000 + 64'(n), 64'h5555_0000_2222_0000 + 64'(n), 0);
        wait_idle();
        chk(idx_o, 32'h1000, "R6 wrap after four narrow records");
        chk(irq_sticky_o, 1, "R7 sticky set at threshold");
        send_br(64'h10, 64'h20, 0);
        wait_idle();
        chk(idx_o, 32'h100C, "R2 narrow record advances 12");
        cfg(3'd5, 32'd1);
        @(negedge clk);
        chk(irq_sticky_o, 0, "R7 sticky cleared by write-1");

        // enable gating and privilege filters
        cfg(3'd4, 32'b00001);
        send_br(64'h30, 64'h40, 0);
        wait_idle();
        chk(idx_o, 32'h100C, "R4 dropped while half-enabled");
        cfg(3'd4, 32'b00111);
        send_br(64'h50, 64'h60, 1);
        wait_idle();
        chk(idx_o, 32'h100C, "R5 kernel branch suppressed");
        send_br(64'h70, 64'h80, 0);
        wait_idle();
        chk(idx_o, 32'h1018, "R5 user branch kept");
        cfg(3'd4, 32'b01011);
        send_br(64'h90, 64'hA0, 0);
        wait_idle();
        chk(idx_o, 32'h1018, "R5 user branch suppressed");
        send_br(64'hB0, 64'hC0, 1);
        wait_idle();
        chk(idx_o, 32'h1024, "R5 kernel branch kept");

        // markers with capture disabled
        cfg(3'd4, 32'b00000);
        send_esc(0, 64'h0123_4567_89AB_CDEF, 64'd77);
        wait_idle();
        chk(idx_o, 32'h1000, "R3 arrival marker written and wrapped");
        send_esc(1, 64'hFEDC_BA98_7654_3210, 64'd78);
        wait_idle();
        chk(idx_o, 32'h100C, "R3 departure marker written");

        // all-zero branch
        cfg(3'd4, 32'b00011);
        send_br(64'h0, 64'h0, 0);
        wait_idle();
        chk(idx_o, 32'h1018, "R12 zero branch stored");

        // marker and branch offered together
        @(negedge clk);
        esc_valid = 1; esc_depart = 0; esc_clock = 64'h99; esc_task = 64'h5;
        br_valid = 1; br_src = 64'hDEAD; br_dst = 64'hBEEF; br_kernel = 0;
        #1;
        chk(esc_ready, 1, "R9 marker taken");
        chk(br_ready, 0, "R9 branch held back");
        @(negedge clk);
        esc_valid = 0;
        #1;
        while (!br_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        br_valid = 0;
        wait_idle();
        chk(idx_o, 32'h1000, "R9 both records written in order");

        // wide mode, threshold beyond end, unaligned base
        cfg(3'd5, 32'd1);
        set_buf(32'h2003, 32'h2000, 32'h2048, 32'h3000);
        cfg(3'd4, 32'b10011);
        for (int n = 0; n < 4; n++) send_br({32'hC0DE_0000 + 32'(n), 32'h1234_0000}, {32'hF00D_0000, 32'h0000_4321 + 32'(n)}, 0);
        wait_idle();
        chk(idx_o, 32'h2018, "R2 R6 wide wrap to aligned base");
        chk(irq_sticky_o, 0, "R7 threshold beyond end never fires");

        // threshold equal to end: wrap and interrupt together
        stall_mode = 0;
        cfg(3'd4, 32'b00011);
        set_buf(32'h1000, 32'h1000, 32'h1018, 32'h1018);
        send_br(64'h1, 64'h2, 0);
        send_br(64'h3, 64'h4, 0);
        wait_idle();
        chk(idx_o, 32'h1000, "R6 wrap on coincident record");
        chk(irq_sticky_o, 1, "R7 interrupt on coincident wrap");

        // start already past threshold
        cfg(3'd5, 32'd1);
        set_buf(32'h1000, 32'h1018, 32'h1030, 32'h100C);
        send_br(64'h5, 64'h6, 0);
        send_br(64'h7, 64'h8, 0);
        wait_idle();
        chk(idx_o, 32'h1000, "R8 filled to end without stall");
        chk(irq_sticky_o, 0, "R8 no repeat interrupt past threshold");
        send_br(64'h9, 64'hA, 0);
        wait_idle();
        chk(irq_sticky_o, 1, "R7 crossing again after wrap");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule